// File: doc/BRIEF.md
# Lockable Read-Only Instruction Cache

A four-way set-associative instruction cache with 16-byte lines and 256 sets (16 KB), where each line is either valid or invalid. The processor side presents a fetch address with a request and holds it until a one-cycle ready pulse returns the 32-bit word. A fetch that misses fetches the whole line from memory as a burst of four words, writes it into a victim way and then answers the fetch.

Writes from the processor are not supported. A write attempt is answered with an error flag and changes nothing. Two maintenance commands drive lines to the invalid state: one clears every line at once, the other clears a single line chosen by set and way. A lock input protects ways 0 and 1, so that a region preloaded into them stays resident. While it is high, replacement uses only ways 2 and 3.

Top module: `ro_icache`

## Requirements
- R1: After reset, fetch_ready_o, fetch_err_o and mem_req_o are low and every line is invalid, so the first fetch to any address misses.
- R2: A read miss raises mem_req_o with mem_addr_o set to the line address (bits 3:0 zero) and holds both steady until four beats have been accepted on mem_valid_i. The beats are taken in word order, so beat k carries byte offset 4k. fetch_ready_o pulses in the cycle after the edge that accepts the fourth beat, carrying the requested word. No other fetch is accepted while the fill is in progress.
- R3: A read hit raises fetch_ready_o in the cycle after the accepting edge, with the cached word, and issues no memory request.
- R4: A fetch with fetch_we_i high gets fetch_ready_o together with fetch_err_o in the cycle after the accepting edge. It makes no memory request and leaves the cache contents unchanged.
- R5: A one-cycle pulse on inv_all_i makes every line invalid.
- R6: A pulse on inv_line_i makes only the line at set inv_set_i and way inv_way_i invalid. Every other line keeps its state.
- R7: On a miss, the victim is the lowest-numbered invalid way among the allowed ways. If every allowed way is valid, a per-set round-robin pointer (reset to 0) picks the victim, and the pointer advances to the next way only when a valid line is replaced.
- R8: While lock_i is high, ways 0 and 1 are never chosen as victims, and the round-robin pointer alternates between ways 2 and 3.
- R9: fetch_ready_o is high for exactly one cycle per accepted fetch.
- R10: The address splits into byte offset [3:0] (word select [3:2]), set index [11:4] and tag [31:12]. Lines that differ only in tag share a set and occupy separate ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Fetch request, held until ready |
| fetch_we_i | input | 1 | Write attempt (unsupported, flagged) |
| fetch_addr_i | input | 32 | Fetch byte address |
| fetch_ready_o | output | 1 | One-cycle completion pulse |
| fetch_rdata_o | output | 32 | Fetched word, valid with ready |
| fetch_err_o | output | 1 | Write attempt rejected, valid with ready |
| mem_req_o | output | 1 | Line fill in progress |
| mem_addr_o | output | 32 | Line-aligned fill address |
| mem_valid_i | input | 1 | Burst beat valid |
| mem_rdata_i | input | 32 | Burst beat data |
| inv_all_i | input | 1 | Invalidate every line |
| inv_line_i | input | 1 | Invalidate one line |
| inv_set_i | input | 8 | Set of the line to invalidate |
| inv_way_i | input | 2 | Way of the line to invalidate |
| lock_i | input | 1 | Protect ways 0 and 1 from replacement |

## Verification
Hits and rejected writes are due in the first cycle after the edge that accepts the request. A miss is due in the cycle after the edge that takes the fourth burst beat, however many idle cycles the memory inserts between beats. The driver counts falling edges from raising the request until ready appears and requires exactly one for hits and writes. For misses it instead requires that the memory model saw exactly one burst start, and for hits and writes none. A monitor samples ready at each falling edge and compares data and error flag against the queued expectation, and the driver confirms that ready is low again one falling edge later.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_RESP} ic_state_e;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
  parameter int WAYS  = 4,
  parameter int SETS  = 256,
  parameter int TAG_W = 20,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] lk_set_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic [WAYS-1:0]  hit_o,
  output logic [WAYS-1:0]  set_valid_o,
  input  logic             alloc_i,
  input  logic [SET_W-1:0] alloc_set_i,
  input  logic [WAY_W-1:0] alloc_way_i,
  input  logic [TAG_W-1:0] alloc_tag_i,
  input  logic             fill_done_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  logic [WAY_W-1:0] fill_way_i,
  input  logic             inv_all_i,
  input  logic             inv_line_i,
  input  logic [SET_W-1:0] inv_set_i,
  input  logic [WAY_W-1:0] inv_way_i
);
  logic [SETS-1:0]  valid_q [WAYS];
  logic [TAG_W-1:0] tag_q   [WAYS][SETS];

  // invalidates are applied last so they win over a fill finishing on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WAYS; w++) valid_q[w] <= '0;
    end else begin
      if (alloc_i)     valid_q[alloc_way_i][alloc_set_i] <= 1'b0;
      if (fill_done_i) valid_q[fill_way_i][fill_set_i]   <= 1'b1;
      if (inv_line_i)  valid_q[inv_way_i][inv_set_i]     <= 1'b0;
      if (inv_all_i)   for (int w = 0; w < WAYS; w++) valid_q[w] <= '0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_i) tag_q[alloc_way_i][alloc_set_i] <= alloc_tag_i;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign set_valid_o[w] = valid_q[w][lk_set_i];
    assign hit_o[w]       = valid_q[w][lk_set_i] && (tag_q[w][lk_set_i] == lk_tag_i);

    p_inv_all_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inv_all_i |=> (valid_q[w] == '0));
    p_inv_line_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inv_line_i && inv_way_i == WAY_W'(w)) |=> !valid_q[w][$past(inv_set_i)]);
  end

  p_single_hit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o));
endmodule

// File: rtl/icache_victim.sv
module icache_victim #(
  parameter int WAYS      = 4,
  parameter int SETS      = 256,
  parameter int LOCK_WAYS = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] set_i,
  input  logic [WAYS-1:0]  set_valid_i,
  input  logic             lock_i,
  input  logic             advance_i,
  output logic [WAY_W-1:0] victim_o,
  output logic             victim_valid_o
);
  logic [WAY_W-1:0] ptr_q [SETS];
  logic [WAY_W-1:0] ptr, nxt;
  logic             found;

  always_comb begin
    found    = 1'b0;
    victim_o = '0;
    ptr      = ptr_q[set_i];
    for (int w = 0; w < WAYS; w++) begin
      if (!found && (!lock_i || w >= LOCK_WAYS) && !set_valid_i[w]) begin
        victim_o = WAY_W'(w);
        found    = 1'b1;
      end
    end
    if (!found) victim_o = (lock_i && ptr < WAY_W'(LOCK_WAYS)) ? WAY_W'(LOCK_WAYS) : ptr;
    victim_valid_o = !found;
    nxt = (victim_o == WAY_W'(WAYS - 1)) ? (lock_i ? WAY_W'(LOCK_WAYS) : '0)
                                         : victim_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (advance_i && victim_valid_o) begin
      ptr_q[set_i] <= nxt;
    end
  end

  p_lock_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && lock_i) |-> (victim_o >= WAY_W'(LOCK_WAYS)));
  p_prefer_invalid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !lock_i && !(&set_valid_i)) |-> !set_valid_i[victim_o]);
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
  parameter int WAYS   = 4,
  parameter int SETS   = 256,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int SET_W  = $clog2(SETS),
  localparam int WORD_W = $clog2(WORDS),
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic                        clk_i,
  input  logic                        wr_en_i,
  input  logic [WAY_W-1:0]            wr_way_i,
  input  logic [SET_W-1:0]            wr_set_i,
  input  logic [WORD_W-1:0]           wr_word_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic [SET_W-1:0]            rd_set_i,
  input  logic [WORD_W-1:0]           rd_word_i,
  output logic [WAYS-1:0][DATA_W-1:0] rd_data_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [DATA_W-1:0] mem_q [SETS*WORDS];
    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_way_i == WAY_W'(w)) mem_q[{wr_set_i, wr_word_i}] <= wr_data_i;
    end
    assign rd_data_o[w] = mem_q[{rd_set_i, rd_word_i}];
  end
endmodule

// File: rtl/ro_icache.sv
module ro_icache
  import icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 256,
  parameter int LINE_WORDS = 4,
  parameter int LOCK_WAYS  = WAYS / 2,
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int WORD_W = $clog2(LINE_WORDS),
  localparam int OFF_W  = BYTE_W + WORD_W,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic              fetch_we_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              fetch_ready_o,
  output logic [DATA_W-1:0] fetch_rdata_o,
  output logic              fetch_err_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              inv_all_i,
  input  logic              inv_line_i,
  input  logic [SET_W-1:0]  inv_set_i,
  input  logic [WAY_W-1:0]  inv_way_i,
  input  logic              lock_i
);
  ic_state_e         state_q;
  logic [SET_W-1:0]  set_q;
  logic [TAG_W-1:0]  tag_q;
  logic [WORD_W-1:0] word_q, beat_q;
  logic [WAY_W-1:0]  way_q;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;

  logic [SET_W-1:0]  lk_set;
  logic [TAG_W-1:0]  lk_tag;
  logic [WORD_W-1:0] lk_word;
  logic              unused_byte_bits;
  assign lk_word = fetch_addr_i[BYTE_W +: WORD_W];
  assign lk_set  = fetch_addr_i[OFF_W +: SET_W];
  assign lk_tag  = fetch_addr_i[ADDR_W-1 -: TAG_W];
  assign unused_byte_bits = ^fetch_addr_i[BYTE_W-1:0];

  logic [WAYS-1:0]             hit, set_valid;
  logic [WAYS-1:0][DATA_W-1:0] way_data;
  logic [DATA_W-1:0]           hit_data;
  logic [WAY_W-1:0]            victim;
  logic                        victim_valid, any_hit, accept, alloc, fill_wr, last_beat;

  assign accept    = (state_q == ST_IDLE) && fetch_req_i;
  assign any_hit   = |hit;
  assign alloc     = accept && !fetch_we_i && !any_hit;
  assign fill_wr   = (state_q == ST_FILL) && mem_valid_i;
  assign last_beat = fill_wr && (beat_q == WORD_W'(LINE_WORDS - 1));

  always_comb begin
    hit_data = '0;
    for (int w = 0; w < WAYS; w++) if (hit[w]) hit_data = hit_data | way_data[w];
  end

  icache_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .lk_set_i(lk_set), .lk_tag_i(lk_tag), .hit_o(hit), .set_valid_o(set_valid),
    .alloc_i(alloc), .alloc_set_i(lk_set), .alloc_way_i(victim), .alloc_tag_i(lk_tag),
    .fill_done_i(last_beat), .fill_set_i(set_q), .fill_way_i(way_q),
    .inv_all_i, .inv_line_i, .inv_set_i, .inv_way_i
  );

  icache_victim #(.WAYS(WAYS), .SETS(SETS), .LOCK_WAYS(LOCK_WAYS)) u_victim (
    .clk_i, .rst_ni, .set_i(lk_set), .set_valid_i(set_valid), .lock_i,
    .advance_i(alloc), .victim_o(victim), .victim_valid_o(victim_valid)
  );

  icache_data_store #(.WAYS(WAYS), .SETS(SETS), .WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
    .clk_i, .wr_en_i(fill_wr), .wr_way_i(way_q), .wr_set_i(set_q), .wr_word_i(beat_q),
    .wr_data_i(mem_rdata_i), .rd_set_i(lk_set), .rd_word_i(lk_word), .rd_data_o(way_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      set_q   <= '0;
      tag_q   <= '0;
      word_q  <= '0;
      beat_q  <= '0;
      way_q   <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (fetch_we_i) begin
            err_q   <= 1'b1;
            state_q <= ST_RESP;
          end else if (any_hit) begin
            rdata_q <= hit_data;
            state_q <= ST_RESP;
          end else begin
            set_q   <= lk_set;
            tag_q   <= lk_tag;
            word_q  <= lk_word;
            way_q   <= victim;
            beat_q  <= '0;
            state_q <= ST_FILL;
          end
        end
        ST_FILL: if (mem_valid_i) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == word_q) rdata_q <= mem_rdata_i;
          if (last_beat) state_q <= ST_RESP;
        end
        ST_RESP: begin
          err_q   <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fetch_ready_o = (state_q == ST_RESP);
  assign fetch_rdata_o = rdata_q;
  assign fetch_err_o   = err_q;
  assign mem_req_o     = (state_q == ST_FILL);
  assign mem_addr_o    = {tag_q, set_q, {OFF_W{1'b0}}};

  p_err_with_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_err_o |-> fetch_ready_o);
  p_write_no_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && fetch_we_i) |=> (fetch_ready_o && !mem_req_o));
  p_hit_no_fill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !fetch_we_i && any_hit) |=> (fetch_ready_o && !mem_req_o));
  p_burst_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !last_beat) |=> (mem_req_o && $stable(mem_addr_o)));
  p_ready_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_ready_o |=> !fetch_ready_o);
  p_alloc_victim_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc && !victim_valid) |-> !set_valid[victim]);
endmodule

// File: tb/ro_icache_tb.sv
module ro_icache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0, fetch_we = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        fetch_ready, fetch_err, mem_req;
  logic [31:0] fetch_rdata, mem_addr;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        inv_all = 1'b0, inv_line = 1'b0, lock = 1'b0;
  logic [7:0]  inv_set = '0;
  logic [1:0]  inv_way = '0;

  int n_chk = 0, n_fail = 0, fills = 0;
  logic [31:0] exp_data_q[$];
  logic        exp_err_q[$];
  string       exp_req_q[$];

  always #2 clk = ~clk;

  ro_icache u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_req_i(fetch_req), .fetch_we_i(fetch_we), .fetch_addr_i(fetch_addr),
    .fetch_ready_o(fetch_ready), .fetch_rdata_o(fetch_rdata), .fetch_err_o(fetch_err),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_valid_i(mem_valid), .mem_rdata_i(mem_rdata),
    .inv_all_i(inv_all), .inv_line_i(inv_line), .inv_set_i(inv_set), .inv_way_i(inv_way),
    .lock_i(lock)
  );

  function automatic logic [31:0] word_of(logic [31:0] a);
    return ({a[31:2], 2'b00} * 32'h9E37_79B1) ^ 32'hA5C3_0F1E;
  endfunction

  function automatic logic [31:0] mk(int tag, int set, int word);
    return {tag[19:0], set[7:0], word[1:0], 2'b00};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // memory model: 4-beat burst, an idle cycle before beat 2 on every other fill
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        logic [31:0] line;
        line = mem_addr;
        chk(line[3:0] == 4'h0, "R2 line aligned", line, {line[31:4], 4'h0});
        for (int b = 0; b < 4; b++) begin
          if (b == 2 && fills[0]) begin
            mem_valid = 1'b0;
            @(negedge clk);
          end
          mem_valid = 1'b1;
          mem_rdata = word_of(line + 32'(4 * b));
          @(negedge clk);
        end
        mem_valid = 1'b0;
        fills++;
      end
    end
  end

  // monitor: compare every response against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (fetch_ready) begin
        if (exp_data_q.size() == 0) begin
          chk(1'b0, "R9 unexpected ready", 32'(fetch_ready), 32'h0);
        end else begin
          logic [31:0] ed;
          logic        ee;
          string       er;
          ed = exp_data_q.pop_front();
          ee = exp_err_q.pop_front();
          er = exp_req_q.pop_front();
          chk(fetch_err == ee, {er, " err"}, 32'(fetch_err), 32'(ee));
          if (!ee) chk(fetch_rdata == ed, {er, " data"}, fetch_rdata, ed);
        end
      end
    end
  end

  // starts and ends at a falling edge
  task automatic fetch(logic [31:0] a, bit we, bit exp_hit, string req);
    int f0, cyc;
    f0 = fills;
    exp_data_q.push_back(word_of(a));
    exp_err_q.push_back(we);
    exp_req_q.push_back(req);
    fetch_req = 1'b1; fetch_we = we; fetch_addr = a;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!fetch_ready && cyc < 400);
    fetch_req = 1'b0; fetch_we = 1'b0;
    if (exp_hit || we) begin
      chk(cyc == 1, {req, " latency"}, 32'(cyc), 32'd1);
      chk(fills == f0, {req, " no fill"}, 32'(fills - f0), 32'd0);
    end else begin
      chk(fills == f0 + 1, {req, " one fill"}, 32'(fills - f0), 32'd1);
    end
    @(negedge clk);
    chk(!fetch_ready, "R9 ready one cycle", 32'(fetch_ready), 32'd0);
  endtask

  task automatic inv_one(int set, int way);
    inv_line = 1'b1; inv_set = 8'(set); inv_way = 2'(way);
    @(negedge clk);
    inv_line = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'h1, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!fetch_ready && !fetch_err, "R1 reset ready/err", {30'b0, fetch_ready, fetch_err}, 32'h0);
    chk(!mem_req, "R1 reset mem_req", 32'(mem_req), 32'h0);

    // R1/R2: cold miss, then hits to the other words of the line (R3)
    fetch(mk(1, 5, 2), 0, 0, "R1 R2 cold miss");
    fetch(mk(1, 5, 0), 0, 1, "R3 hit w0");
    fetch(mk(1, 5, 3), 0, 1, "R3 hit w3");
    fetch(mk(1, 5, 1), 0, 1, "R3 hit w1");
    fetch(mk(7, 6, 3), 0, 0, "R2 miss last word");
    fetch(mk(7, 6, 0), 0, 1, "R3 hit set6");

    // R4: write attempt rejected, line intact
    fetch(mk(1, 5, 1), 1, 0, "R4 write err");
    fetch(mk(1, 5, 1), 0, 1, "R4 line unchanged");
    fetch(mk(9, 7, 0), 1, 0, "R4 write to absent line");
    fetch(mk(9, 7, 0), 0, 0, "R4 no alloc on write");

    // R10/R7: fill set 5 (tag1 w0, tag2 w1, tag3 w2, tag4 w3), then round robin
    fetch(mk(2, 5, 0), 0, 0, "R10 same set tag2");
    fetch(mk(3, 5, 1), 0, 0, "R10 same set tag3");
    fetch(mk(4, 5, 2), 0, 0, "R10 same set tag4");
    fetch(mk(1, 5, 2), 0, 1, "R10 tag1 still held");
    fetch(mk(5, 5, 0), 0, 0, "R7 replace w0");
    fetch(mk(1, 5, 0), 0, 0, "R7 tag1 evicted, refill w1");
    fetch(mk(2, 5, 0), 0, 0, "R7 tag2 evicted, refill w2");
    fetch(mk(4, 5, 3), 0, 1, "R7 tag4 kept");
    fetch(mk(5, 5, 1), 0, 1, "R7 tag5 kept");

    // R6: single-line invalidate (set5 way3 holds tag4, set6 way1 is empty)
    inv_one(5, 3);
    inv_one(6, 1);
    fetch(mk(7, 6, 1), 0, 1, "R6 other set kept");
    fetch(mk(5, 5, 2), 0, 1, "R6 neighbour way kept");
    fetch(mk(4, 5, 0), 0, 0, "R6 target line missed");
    fetch(mk(1, 5, 3), 0, 1, "R7 invalid way preferred");
    fetch(mk(2, 5, 3), 0, 1, "R7 invalid way preferred 2");

    // R8: lock protects ways 0 and 1 of set 9
    fetch(mk(10, 9, 0), 0, 0, "R8 preload w0");
    fetch(mk(11, 9, 0), 0, 0, "R8 preload w1");
    fetch(mk(12, 9, 0), 0, 0, "R8 fill w2");
    fetch(mk(13, 9, 0), 0, 0, "R8 fill w3");
    lock = 1'b1;
    fetch(mk(14, 9, 1), 0, 0, "R8 locked miss to w2");
    fetch(mk(15, 9, 2), 0, 0, "R8 locked miss to w3");
    fetch(mk(10, 9, 3), 0, 1, "R8 w0 kept");
    fetch(mk(11, 9, 2), 0, 1, "R8 w1 kept");
    fetch(mk(12, 9, 0), 0, 0, "R8 tag12 evicted");
    fetch(mk(15, 9, 0), 0, 1, "R8 pointer alternates");
    fetch(mk(13, 9, 0), 0, 0, "R8 tag13 evicted");
    fetch(mk(10, 9, 1), 0, 1, "R8 w0 still kept");
    fetch(mk(11, 9, 1), 0, 1, "R8 w1 still kept");
    lock = 1'b0;

    // R5: invalidate everything
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    @(negedge clk);
    fetch(mk(5, 5, 0), 0, 0, "R5 set5 missed");
    fetch(mk(7, 6, 0), 0, 0, "R5 set6 missed");
    fetch(mk(10, 9, 0), 0, 0, "R5 locked way missed");
    fetch(mk(7, 6, 2), 0, 1, "R5 refilled line hits");

    repeat (4) @(negedge clk);
    chk(exp_data_q.size() == 0, "R9 all responses seen", 32'(exp_data_q.size()), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule